// File: doc/BRIEF.md
# USB3 Mode Bring-Up Sequencer for a Shared USB3/PCIe SerDes PHY

This block brings a SerDes PHY that can serve either USB3 or PCIe into USB3 operation without software stepping it through each access. A one-cycle `start_i` pulse begins the run. The block first holds the PHY reset high for a fixed number of cycles and then releases it. Next it writes the mode-select field of a local configuration word. After that it walks a fixed script of five read-modify-write updates to internal PHY registers. It issues these through a request port that feeds an external control-register bus master. Finally it programs the transmit voltage boost field and the loss-of-signal fields in two more local configuration words, and then it raises `done_o`.

The script always runs in the same order. Each update reads one internal register, clears the bits under a fixed mask, ORs in a fixed value and writes the result back to the same address. Only one bus request is outstanding at any time. The sequencer moves to the next access only when the master acknowledges the current one. If the master flags a failure on any acknowledgement, the run stops at that point and `error_o` stays high. The `exit_i` input aborts whatever is in progress and puts the PHY back into reset.

Top module: `phy_u3_init_seq`

## Requirements
- R1: After `rst_n` is released, `phy_rst_o`, `cr_req_o`, `done_o` and `error_o` are 0, and `cfg0_o`, `cfg1_o` and `cfg2_o` are all zero.
- R2: A `start_i` pulse accepted in the idle, done or error state drives `phy_rst_o` high for exactly `RST_CYCLES` cycles and then low. No bus request is made while `phy_rst_o` is high.
- R3: On the edge after `phy_rst_o` falls, `cfg0_o[6:5]` becomes 2'b11 (the USB3 selection) and the other bits of `cfg0_o` keep their values. The first bus request follows on the edge after that.
- R4: `cr_wr_o` is 0 for a read and 1 for a write. Once `cr_req_o` is high, it stays high with `cr_addr_o`, `cr_wr_o` and `cr_wdata_o` unchanged until the edge on which `cr_done_i` is seen. Only one request is open at a time.
- R5: A complete run makes exactly ten accesses. Each of the addresses 0x102D, 0x1010, 0x1006, 0x1002 and 0x0030, in that order, gets a read followed by a write to the same address.
- R6: Each write carries (read data AND NOT mask) OR value, with these mask/value pairs: 0x102D 0x0004/0x0004 (alternate transmit bus enable, bit 2); 0x1010 0x0FF0/0x0014; 0x1006 0x0F00/0x0B00 (receive equaliser override with equaliser value 3); 0x1002 0x7FFF/0x4B7F (amplitude 0x7F at bits 6:0, pre-emphasis 22 at bits 13:7, override enable at bit 14); 0x0030 0x001E/0x0010 (loop proportional control 8 at bits 4:1).
- R7: After a run without errors, `cfg2_o[20:18]` = 4, `cfg1_o[23:21]` = 4 and `cfg1_o[20:16]` = 9, and all other bits keep their values. `done_o` rises on the second edge after the edge that takes the final write acknowledgement. `done_o` and `error_o` are never high together.
- R8: An acknowledgement with `cr_err_i` = 1 ends the run. On the next edge `error_o` is 1 and `cr_req_o` is 0. No further access is made, `cfg1_o` and `cfg2_o` are left unchanged, and `error_o` stays high until the next `start_i` or `exit_i`.
- R9: On the edge after `exit_i`, `phy_rst_o` is 1 and `cr_req_o`, `done_o` and `error_o` are 0. The PHY stays in reset and no access is made until a later `start_i` pulse completes its reset phase.
- R10: A `start_i` pulse during a run is ignored, so the run still makes exactly ten accesses. A `start_i` pulse after `done_o` runs the full sequence again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Pulse that begins the bring-up sequence |
| exit_i | input | 1 | Pulse that aborts the run and puts the PHY back into reset |
| phy_rst_o | output | 1 | PHY reset, active high |
| cr_req_o | output | 1 | Bus request to the control-register master |
| cr_wr_o | output | 1 | Request kind: 0 read, 1 write |
| cr_addr_o | output | CR_AW | Internal register address |
| cr_wdata_o | output | CR_DW | Write data |
| cr_done_i | input | 1 | One-cycle acknowledgement of the open request |
| cr_err_i | input | 1 | Failure flag, valid together with `cr_done_i` |
| cr_rdata_i | input | CR_DW | Read data, valid together with `cr_done_i` |
| done_o | output | 1 | Sequence finished without error |
| error_o | output | 1 | Sequence stopped on a bus failure |
| cfg0_o | output | CFG_W | Local configuration word holding the mode select |
| cfg1_o | output | CFG_W | Local configuration word holding the loss-of-signal bias and level |
| cfg2_o | output | CFG_W | Local configuration word holding the transmit boost |

## Verification
Every result has a fixed distance in edges from the stimulus that causes it. The reset output is high for exactly `RST_CYCLES` edges after the start edge. The mode field appears one edge after reset release, and the first request appears one edge after that. `error_o` follows a failing acknowledgement by one edge, and `done_o` follows the final write acknowledgement by two edges. The bench keeps its own edge counter and records it when its bus model drives each acknowledgement. It then compares that count with the count at which the status output is first seen, and it samples all outputs on the falling edge, so each check lands on the exact cycle it predicts.

// File: rtl/phy_u3_pkg.sv
package phy_u3_pkg;

   typedef enum logic [3:0] {
      S_IDLE,
      S_RST,
      S_MODE,
      S_GO,
      S_WAIT,
      S_BOOST,
      S_LOS,
      S_DONE,
      S_ERR
   } seq_state_e;

   typedef enum logic [1:0] {
      M_IDLE,
      M_RD,
      M_WR
   } rmw_state_e;

   typedef struct packed {
      logic [15:0] addr;
      logic [15:0] mask;
      logic [15:0] val;
   } rmw_step_t;

   localparam int NUM_STEPS = 5;
   localparam int NUM_CFG   = 3;

   // fixed update script, applied in index order
   function automatic rmw_step_t script_step(input int idx);
      rmw_step_t s;
      case (idx)
         0:       s = '{addr: 16'h102D, mask: 16'h0004, val: 16'h0004};
         1:       s = '{addr: 16'h1010, mask: 16'h0FF0, val: 16'h0014};
         2:       s = '{addr: 16'h1006, mask: 16'h0F00, val: 16'h0B00};
         3:       s = '{addr: 16'h1002, mask: 16'h7FFF, val: 16'h4B7F};
         default: s = '{addr: 16'h0030, mask: 16'h001E, val: 16'h0010};
      endcase
      return s;
   endfunction

   // local word 0: mode select, 1: loss-of-signal, 2: tx boost
   function automatic logic [31:0] cfg_mask(input int idx);
      case (idx)
         0:       return 32'h0000_0060;
         1:       return 32'h00FF_0000;
         default: return 32'h001C_0000;
      endcase
   endfunction

   function automatic logic [31:0] cfg_val(input int idx);
      case (idx)
         0:       return 32'h0000_0060;
         1:       return 32'h0089_0000;
         default: return 32'h0010_0000;
      endcase
   endfunction

endpackage

// File: rtl/phy_u3_rst_timer.sv
module phy_u3_rst_timer #(
   parameter int RST_CYCLES = 16
) (
   input  logic clk,
   input  logic rst_n,
   input  logic load_i,
   output logic exp_o
);
   localparam int CW = (RST_CYCLES > 1) ? $clog2(RST_CYCLES) : 1;
   localparam logic [CW-1:0] LAST = CW'(RST_CYCLES - 1);

   logic [CW-1:0] cnt_q;
   logic          run_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
         run_q <= 1'b0;
      end else if (load_i) begin
         cnt_q <= '0;
         run_q <= 1'b1;
      end else if (run_q) begin
         if (cnt_q == LAST) run_q <= 1'b0;
         else               cnt_q <= cnt_q + 1'b1;
      end
   end

   assign exp_o = run_q && (cnt_q == LAST);
endmodule

// File: rtl/phy_u3_cr_rmw.sv
module phy_u3_cr_rmw
   import phy_u3_pkg::*;
#(
   parameter int CR_AW = 16,
   parameter int CR_DW = 16,
   parameter int SW    = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             go_i,
   input  logic             abort_i,
   input  logic [SW-1:0]    step_i,
   output logic             req_o,
   output logic             wr_o,
   output logic [CR_AW-1:0] addr_o,
   output logic [CR_DW-1:0] wdata_o,
   input  logic             done_i,
   input  logic             err_i,
   input  logic [CR_DW-1:0] rdata_i,
   output logic             fin_o,
   output logic             fail_o
);
   rmw_state_e       st_q;
   logic [CR_DW-1:0] mask_q, val_q, wdata_q;
   logic [CR_AW-1:0] addr_q;
   rmw_step_t        cur;

   always_comb cur = script_step(int'(step_i));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q    <= M_IDLE;
         addr_q  <= '0;
         mask_q  <= '0;
         val_q   <= '0;
         wdata_q <= '0;
      end else if (abort_i) begin
         st_q <= M_IDLE;
      end else begin
         case (st_q)
            M_IDLE: if (go_i) begin
               st_q   <= M_RD;
               addr_q <= CR_AW'(cur.addr);
               mask_q <= CR_DW'(cur.mask);
               val_q  <= CR_DW'(cur.val);
            end
            M_RD: if (done_i) begin
               if (err_i) st_q <= M_IDLE;
               else begin
                  st_q    <= M_WR;
                  wdata_q <= (rdata_i & ~mask_q) | val_q;
               end
            end
            M_WR: if (done_i) st_q <= M_IDLE;
            default: st_q <= M_IDLE;
         endcase
      end
   end

   assign req_o   = (st_q != M_IDLE);
   assign wr_o    = (st_q == M_WR);
   assign addr_o  = addr_q;
   assign wdata_o = wdata_q;
   assign fin_o   = (st_q == M_WR) && done_i && !err_i;
   assign fail_o  = (st_q != M_IDLE) && done_i && err_i;
endmodule

// File: rtl/phy_u3_cfg_bank.sv
module phy_u3_cfg_bank
   import phy_u3_pkg::*;
#(
   parameter int CFG_W = 32,
   parameter int NUM   = NUM_CFG
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic [NUM-1:0]            set_i,
   output logic [NUM-1:0][CFG_W-1:0] q_o
);
   for (genvar i = 0; i < NUM; i++) begin : g_word
      localparam logic [CFG_W-1:0] MSK = CFG_W'(cfg_mask(i));
      localparam logic [CFG_W-1:0] VAL = CFG_W'(cfg_val(i));
      logic [CFG_W-1:0] w_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)        w_q <= '0;
         else if (set_i[i]) w_q <= (w_q & ~MSK) | VAL;
      end

      assign q_o[i] = w_q;
   end
endmodule

// File: rtl/phy_u3_init_seq.sv
module phy_u3_init_seq
   import phy_u3_pkg::*;
#(
   parameter int RST_CYCLES = 16,
   parameter int CR_AW      = 16,
   parameter int CR_DW      = 16,
   parameter int CFG_W      = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_i,
   input  logic             exit_i,
   output logic             phy_rst_o,
   output logic             cr_req_o,
   output logic             cr_wr_o,
   output logic [CR_AW-1:0] cr_addr_o,
   output logic [CR_DW-1:0] cr_wdata_o,
   input  logic             cr_done_i,
   input  logic             cr_err_i,
   input  logic [CR_DW-1:0] cr_rdata_i,
   output logic             done_o,
   output logic             error_o,
   output logic [CFG_W-1:0] cfg0_o,
   output logic [CFG_W-1:0] cfg1_o,
   output logic [CFG_W-1:0] cfg2_o
);
   localparam int SW = $clog2(NUM_STEPS);
   localparam logic [SW-1:0] LAST_STEP = SW'(NUM_STEPS - 1);

   if (RST_CYCLES < 1) begin : g_bad_rst
      $error("RST_CYCLES must be at least 1");
   end
   if (CR_AW < 16 || CR_DW < 16) begin : g_bad_bus
      $error("bus address and data must be at least 16 bits");
   end
   if (CFG_W < 24) begin : g_bad_cfg
      $error("CFG_W must cover bit 23");
   end

   seq_state_e    st_q;
   logic [SW-1:0] step_q;
   logic          prst_q;
   logic          accept, tmr_exp, go, fin, fail;
   logic [NUM_CFG-1:0]            cfg_set;
   logic [NUM_CFG-1:0][CFG_W-1:0] cfg_q;

   assign accept = start_i && !exit_i &&
                   (st_q == S_IDLE || st_q == S_DONE || st_q == S_ERR);
   assign go     = (st_q == S_GO);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= S_IDLE;
         step_q <= '0;
         prst_q <= 1'b0;
      end else if (exit_i) begin
         st_q   <= S_IDLE;
         prst_q <= 1'b1;
      end else begin
         case (st_q)
            S_IDLE, S_DONE, S_ERR: if (accept) begin
               st_q   <= S_RST;
               prst_q <= 1'b1;
            end
            S_RST: if (tmr_exp) begin
               st_q   <= S_MODE;
               prst_q <= 1'b0;
            end
            S_MODE: begin
               st_q   <= S_GO;
               step_q <= '0;
            end
            S_GO: st_q <= S_WAIT;
            S_WAIT: begin
               if (fail) st_q <= S_ERR;
               else if (fin) begin
                  if (step_q == LAST_STEP) st_q <= S_BOOST;
                  else begin
                     step_q <= step_q + 1'b1;
                     st_q   <= S_GO;
                  end
               end
            end
            S_BOOST: st_q <= S_LOS;
            S_LOS:   st_q <= S_DONE;
            default: st_q <= S_IDLE;
         endcase
      end
   end

   phy_u3_rst_timer #(.RST_CYCLES(RST_CYCLES)) u_tmr (
      .clk    (clk),
      .rst_n  (rst_n),
      .load_i (accept),
      .exp_o  (tmr_exp)
   );

   phy_u3_cr_rmw #(.CR_AW(CR_AW), .CR_DW(CR_DW), .SW(SW)) u_rmw (
      .clk     (clk),
      .rst_n   (rst_n),
      .go_i    (go),
      .abort_i (exit_i),
      .step_i  (step_q),
      .req_o   (cr_req_o),
      .wr_o    (cr_wr_o),
      .addr_o  (cr_addr_o),
      .wdata_o (cr_wdata_o),
      .done_i  (cr_done_i),
      .err_i   (cr_err_i),
      .rdata_i (cr_rdata_i),
      .fin_o   (fin),
      .fail_o  (fail)
   );

   assign cfg_set[0] = (st_q == S_MODE)  && !exit_i;
   assign cfg_set[1] = (st_q == S_LOS)   && !exit_i;
   assign cfg_set[2] = (st_q == S_BOOST) && !exit_i;

   phy_u3_cfg_bank #(.CFG_W(CFG_W), .NUM(NUM_CFG)) u_cfg (
      .clk   (clk),
      .rst_n (rst_n),
      .set_i (cfg_set),
      .q_o   (cfg_q)
   );

   assign phy_rst_o = prst_q;
   assign done_o    = (st_q == S_DONE);
   assign error_o   = (st_q == S_ERR);
   assign cfg0_o    = cfg_q[0];
   assign cfg1_o    = cfg_q[1];
   assign cfg2_o    = cfg_q[2];
endmodule

// File: rtl/phy_u3_init_seq_chk.sv
module phy_u3_init_seq_chk #(
   parameter int CR_AW = 16,
   parameter int CR_DW = 16,
   parameter int CFG_W = 32
) (
   input logic             clk,
   input logic             rst_n,
   input logic             start_i,
   input logic             exit_i,
   input logic             phy_rst_o,
   input logic             cr_req_o,
   input logic             cr_wr_o,
   input logic [CR_AW-1:0] cr_addr_o,
   input logic [CR_DW-1:0] cr_wdata_o,
   input logic             cr_done_i,
   input logic             cr_err_i,
   input logic             done_o,
   input logic             error_o,
   input logic [CFG_W-1:0] cfg0_o,
   input logic [CFG_W-1:0] cfg1_o,
   input logic [CFG_W-1:0] cfg2_o
);
   assert_no_req_in_reset_R2: assert property (@(posedge clk) disable iff (!rst_n)
      phy_rst_o |-> !cr_req_o);

   assert_req_held_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (cr_req_o && !cr_done_i && !exit_i) |=>
      (cr_req_o && $stable(cr_addr_o) && $stable(cr_wr_o) && $stable(cr_wdata_o)));

   assert_write_follows_read_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (cr_req_o && !cr_wr_o && cr_done_i && !cr_err_i && !exit_i) |=>
      (cr_req_o && cr_wr_o && $stable(cr_addr_o)));

   assert_done_fields_R7: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> (cfg0_o[6:5] == 2'b11 && cfg1_o[23:21] == 3'd4 &&
                  cfg1_o[20:16] == 5'd9 && cfg2_o[20:18] == 3'd4));

   assert_done_error_excl_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !(done_o && error_o));

   assert_err_stops_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (cr_req_o && cr_done_i && cr_err_i && !exit_i) |=> (error_o && !cr_req_o));

   assert_err_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (error_o && !start_i && !exit_i) |=> (error_o && !cr_req_o));

   assert_exit_R9: assert property (@(posedge clk) disable iff (!rst_n)
      exit_i |=> (phy_rst_o && !cr_req_o && !done_o && !error_o));
endmodule

bind phy_u3_init_seq phy_u3_init_seq_chk #(
   .CR_AW(CR_AW), .CR_DW(CR_DW), .CFG_W(CFG_W)
) u_chk (
   .clk(clk), .rst_n(rst_n), .start_i(start_i), .exit_i(exit_i),
   .phy_rst_o(phy_rst_o), .cr_req_o(cr_req_o), .cr_wr_o(cr_wr_o),
   .cr_addr_o(cr_addr_o), .cr_wdata_o(cr_wdata_o), .cr_done_i(cr_done_i),
   .cr_err_i(cr_err_i), .done_o(done_o), .error_o(error_o),
   .cfg0_o(cfg0_o), .cfg1_o(cfg1_o), .cfg2_o(cfg2_o)
);

// File: tb/phy_u3_init_seq_tb.sv
module phy_u3_init_seq_tb;
   localparam int RSTC = 16;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start_i = 1'b0, exit_i = 1'b0;
   logic        phy_rst_o, cr_req_o, cr_wr_o, done_o, error_o;
   logic [15:0] cr_addr_o, cr_wdata_o;
   logic        cr_done_i = 1'b0, cr_err_i = 1'b0;
   logic [15:0] cr_rdata_i = '0;
   logic [31:0] cfg0_o, cfg1_o, cfg2_o;

   always #4 clk = ~clk;

   phy_u3_init_seq #(.RST_CYCLES(RSTC)) u_dut (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .exit_i(exit_i),
      .phy_rst_o(phy_rst_o), .cr_req_o(cr_req_o), .cr_wr_o(cr_wr_o),
      .cr_addr_o(cr_addr_o), .cr_wdata_o(cr_wdata_o), .cr_done_i(cr_done_i),
      .cr_err_i(cr_err_i), .cr_rdata_i(cr_rdata_i), .done_o(done_o),
      .error_o(error_o), .cfg0_o(cfg0_o), .cfg1_o(cfg1_o), .cfg2_o(cfg2_o)
   );

   int n_chk = 0, n_bad = 0;
   int cyc = 0;
   bit finished = 0;

   always @(posedge clk) cyc <= cyc + 1;

   task automatic check(input string req, input bit ok, input longint act, input longint exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // bus model state
   logic [15:0] mem [int];
   int lat = 1, err_at = -1, acc_cnt = 0, wait_cnt = 0, ack_cyc = 0;
   logic [15:0] log_addr [16];
   logic        log_wr   [16];
   int hold_bad = 0;

   // expected script, from the requirements
   localparam logic [15:0] A [5] = '{16'h102D, 16'h1010, 16'h1006, 16'h1002, 16'h0030};
   localparam logic [15:0] M [5] = '{16'h0004, 16'h0FF0, 16'h0F00, 16'h7FFF, 16'h001E};
   localparam logic [15:0] V [5] = '{16'h0004, 16'h0014, 16'h0B00, 16'h4B7F, 16'h0010};

   initial begin
      forever begin
         @(negedge clk);
         if (cr_done_i) begin
            cr_done_i = 1'b0;
            cr_err_i  = 1'b0;
         end else if (cr_req_o) begin
            wait_cnt++;
            if (wait_cnt >= lat) begin
               wait_cnt = 0;
               if (acc_cnt < 16) begin
                  log_addr[acc_cnt] = cr_addr_o;
                  log_wr[acc_cnt]   = cr_wr_o;
               end
               if (acc_cnt == err_at) cr_err_i = 1'b1;
               else if (cr_wr_o) mem[int'(cr_addr_o)] = cr_wdata_o;
               else cr_rdata_i = mem.exists(int'(cr_addr_o)) ? mem[int'(cr_addr_o)] : 16'h0;
               cr_done_i = 1'b1;
               ack_cyc = cyc;
               acc_cnt++;
            end
         end else wait_cnt = 0;
      end
   end

   // R4 monitor: open request must not change until acknowledged
   logic        p_req = 0, p_wr = 0, p_done = 0;
   logic [15:0] p_addr = 0, p_wd = 0;
   always @(negedge clk) begin
      if (rst_n && p_req && !p_done && !exit_i && cr_req_o &&
          (cr_addr_o != p_addr || cr_wr_o != p_wr || cr_wdata_o != p_wd)) hold_bad++;
      if (rst_n && p_req && !p_done && !exit_i && !cr_req_o) hold_bad++;
      p_req = cr_req_o; p_wr = cr_wr_o; p_addr = cr_addr_o; p_wd = cr_wdata_o;
      p_done = cr_done_i;
   end

   task automatic preload(input logic [15:0] v0, v1, v2, v3, v4);
      mem[int'(A[0])] = v0; mem[int'(A[1])] = v1; mem[int'(A[2])] = v2;
      mem[int'(A[3])] = v3; mem[int'(A[4])] = v4;
   endtask

   task automatic pulse_start();
      @(negedge clk); start_i = 1'b1;
      @(negedge clk); start_i = 1'b0;
   endtask

   task automatic do_reset();
      @(negedge clk); rst_n = 1'b0;
      @(negedge clk); @(negedge clk); rst_n = 1'b1;
      @(negedge clk);
   endtask

   task automatic t_reset();
      check("R1 phy_rst", phy_rst_o == 1'b0, phy_rst_o, 0);
      check("R1 req/done/err", {cr_req_o, done_o, error_o} == 3'b0, {cr_req_o, done_o, error_o}, 0);
      check("R1 cfg", cfg0_o == 0 && cfg1_o == 0 && cfg2_o == 0, cfg0_o | cfg1_o | cfg2_o, 0);
   endtask

   task automatic t_run(input int lat_v, input bit first, input bit poke,
                        input logic [15:0] i0, i1, i2, i3, i4);
      logic [15:0] ini [5];
      int n = 0, t = 0, hb0 = hold_bad;
      bit req_seen = 0;
      ini = '{i0, i1, i2, i3, i4};
      lat = lat_v; err_at = -1;
      preload(i0, i1, i2, i3, i4);
      acc_cnt = 0;
      pulse_start();
      while (phy_rst_o === 1'b1 && n < 1000) begin
         n++;
         if (cr_req_o) req_seen = 1;
         @(negedge clk);
      end
      if (first) begin
         check("R2 reset pulse width", n == RSTC, n, RSTC);
         check("R2 no request during reset", !req_seen, req_seen, 0);
         check("R3 mode not yet set", cfg0_o == 0, cfg0_o, 0);
         @(negedge clk);
         check("R3 mode field set", cfg0_o == 32'h60, cfg0_o, 32'h60);
         check("R3 no request yet", !cr_req_o, cr_req_o, 0);
         @(negedge clk);
         check("R3 first request", cr_req_o && !cr_wr_o && cr_addr_o == A[0], cr_addr_o, A[0]);
      end
      if (poke) begin
         while (acc_cnt < 3) @(negedge clk);
         start_i = 1'b1; @(negedge clk); start_i = 1'b0;
      end
      while (!done_o && !error_o && t < 5000) begin t++; @(negedge clk); end
      check("R7 done reached", done_o && !error_o, {done_o, error_o}, 2'b10);
      check("R7 done two edges after last ack", cyc - ack_cyc == 3, cyc - ack_cyc, 3);
      check(poke ? "R10 start mid-run ignored, access count" : "R5 access count",
            acc_cnt == 10, acc_cnt, 10);
      for (int k = 0; k < 10; k++)
         check("R5 access order", log_addr[k] == A[k/2] && log_wr[k] == k[0],
               {log_wr[k], log_addr[k]}, {k[0], A[k/2]});
      for (int k = 0; k < 5; k++)
         check("R6 written value", mem[int'(A[k])] == ((ini[k] & ~M[k]) | V[k]),
               mem[int'(A[k])], (ini[k] & ~M[k]) | V[k]);
      check("R7 cfg1 los fields", cfg1_o == 32'h0089_0000, cfg1_o, 32'h0089_0000);
      check("R7 cfg2 boost field", cfg2_o == 32'h0010_0000, cfg2_o, 32'h0010_0000);
      check("R4 request held until ack", hold_bad == hb0, hold_bad - hb0, 0);
   endtask

   task automatic t_error();
      int t = 0;
      do_reset();
      preload(16'h1111, 16'h2222, 16'h3333, 16'h4444, 16'h5555);
      lat = 2; err_at = 4; acc_cnt = 0;
      pulse_start();
      while (!error_o && t < 5000) begin t++; @(negedge clk); end
      check("R8 error one edge after failing ack", error_o && cyc - ack_cyc == 1, cyc - ack_cyc, 1);
      check("R8 request dropped", !cr_req_o && !done_o, {cr_req_o, done_o}, 0);
      repeat (30) @(negedge clk);
      check("R8 no further access", acc_cnt == 5, acc_cnt, 5);
      check("R8 error held", error_o, error_o, 1);
      check("R8 failed address untouched", mem[int'(A[2])] == 16'h3333, mem[int'(A[2])], 16'h3333);
      check("R8 cfg1/cfg2 unchanged", cfg1_o == 0 && cfg2_o == 0, cfg1_o | cfg2_o, 0);
      check("R3 mode kept after error", cfg0_o == 32'h60, cfg0_o, 32'h60);
      exit_i = 1'b1; @(negedge clk); exit_i = 1'b0;
      check("R9 exit from error", phy_rst_o && !error_o && !done_o, {phy_rst_o, error_o, done_o}, 3'b100);
   endtask

   task automatic t_exit();
      int c0;
      err_at = -1; lat = 2; acc_cnt = 0;
      preload(16'h0, 16'h0, 16'h0, 16'h0, 16'h0);
      pulse_start();
      while (acc_cnt < 3) @(negedge clk);
      exit_i = 1'b1; @(negedge clk); exit_i = 1'b0;
      check("R9 exit mid-run", phy_rst_o && !cr_req_o && !done_o, {phy_rst_o, cr_req_o, done_o}, 3'b100);
      c0 = acc_cnt;
      repeat (40) @(negedge clk);
      check("R9 stays in reset, no access", phy_rst_o && acc_cnt == c0, acc_cnt, c0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_run(1, 1'b1, 1'b0, 16'h1230, 16'hABCD, 16'hFFFF, 16'h8000, 16'hFFFF);
      t_run(3, 1'b0, 1'b1, 16'h0000, 16'h0000, 16'h0000, 16'h0000, 16'h0000); // R10 restart
      t_error();
      t_exit();
      if (!finished) begin
         finished = 1;
         $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
         $finish;
      end
   end

   initial begin
      #(8 * 100000);
      if (!finished) begin
         finished = 1;
         n_chk++; n_bad++;
         $display("FAIL watchdog actual=timeout expected=completion");
         $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
         $finish;
      end
   end
endmodule